// File: doc/BRIEF.md
# Shift-Add Constant Multiplier Datapath

This block multiplies an integer by a small fixed constant without a hardware multiplier. It holds a small register file. An external sequencer feeds it one micro-instruction per cycle, and each instruction combines two registers with a scaled add, a subtract or a left shift. A multiply by a constant is written as a short chain of these steps. Multiplying by ten takes two steps and multiplying by fifty-nine takes three.

To use it, load the operand into register 0, issue the chain of instructions, and read the product from whichever register the chain last wrote. All arithmetic wraps modulo 2^32. The block does not detect overflow, and it does not choose the instruction chain for a given constant.

Top module: `shadd_cmul`

## Requirements
- R1: While `rst_n` is low, every register is cleared to zero, and each one reads back as zero after reset is released.
- R2: When `ld_en` is high at a clock edge, register 0 takes `ld_data`. Any instruction offered in the same cycle is dropped and changes no register.
- R3: Opcode 2'b00 is the scaled add. It writes `(A << amt[1:0]) + B` to the destination, so it scales A by 1, 2, 4 or 8. Bits `amt[4:2]` do not affect the result.
- R4: Opcode 2'b01 is the subtract. It writes `A - B` to the destination, wrapping modulo 2^32.
- R5: Opcode 2'b10 is the left shift. It writes `A << amt` to the destination, where `amt` is 5 bits. With `amt` = 0 the value is copied unchanged.
- R6: Opcode 2'b11 changes no register. An idle cycle (`ins_valid` low and `ld_en` low) also changes no register.
- R7: An instruction writes at the clock edge that accepts it. The next instruction can use that result as a source. An instruction whose destination is also a source reads the value held before the edge.
- R8: Every result is the low 32 bits of the exact arithmetic result. Nothing saturates and nothing is flagged.
- R9: `rd_data` always shows the register selected by `rd_addr`, with no cycle of delay.
- R10: The chain r1=(r0<<2)+r0, r1=r1+r1 leaves s*10 in r1. The chain r2=(r0<<1)+r0, r3=(r2<<1)+r0, r3=(r3<<3)+r2 leaves s*59 in r3. Both products are taken modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load operand into register 0 |
| ld_data | input | 32 | Operand value |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_op | input | 2 | Opcode: 00 scaled add, 01 subtract, 10 shift, 11 no-op |
| ins_dst | input | 3 | Destination register |
| ins_srca | input | 3 | Source A (scaled or shifted operand) |
| ins_srcb | input | 3 | Source B (addend or subtrahend) |
| ins_amt | input | 5 | Shift amount; the scaled add uses only the low two bits |
| rd_addr | input | 3 | Read register select |
| rd_data | output | 32 | Selected register value |

## Verification
The register-update assertions assume that the sequencer drives `ins_op`, the register indices and `ins_amt` to known values whenever `ins_valid` or `ld_en` is high. They also assume that a register index never reaches past the register count. At the default size every 3-bit index is in range. The bench drives every instruction field from an initial block on the falling edge and holds it stable through the following rising edge. The random instructions draw indices from the full 3-bit range and shift amounts from the full 5-bit range, so every encoding the assertions cover is legal.

// File: rtl/shadd_cmul.sv
module shadd_cmul #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int SHW  = 5,
  localparam int AW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_en,
  input  logic [DW-1:0]  ld_data,
  input  logic           ins_valid,
  input  logic [1:0]     ins_op,
  input  logic [AW-1:0]  ins_dst,
  input  logic [AW-1:0]  ins_srca,
  input  logic [AW-1:0]  ins_srcb,
  input  logic [SHW-1:0] ins_amt,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data
);

  localparam logic [1:0] OP_SADD = 2'b00;
  localparam logic [1:0] OP_SUB  = 2'b01;
  localparam logic [1:0] OP_SHL  = 2'b10;
  localparam logic [1:0] OP_NOP  = 2'b11;

  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0] opa, opb, res;
  logic wr;

  assign opa     = regs[ins_srca];
  assign opb     = regs[ins_srcb];
  assign rd_data = regs[rd_addr];
  assign wr      = ins_valid && !ld_en && (ins_op != OP_NOP);

  always_comb begin
    case (ins_op)
      OP_SADD: res = (opa << ins_amt[1:0]) + opb;
      OP_SUB:  res = opa - opb;
      OP_SHL:  res = opa << ins_amt;
      default: res = opa;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      regs <= '0;
    else if (ld_en)
      regs[0] <= ld_data;
    else if (wr)
      regs[ins_dst] <= res;
  end

  // R2: load lands in register 0 one edge later
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> regs[0] == $past(ld_data));

  // R3, R7, R8: scaled add result visible after the accepting edge
  p_sadd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ld_en && ins_op == OP_SADD) |=>
      regs[$past(ins_dst)] == DW'(($past(opa) << $past(ins_amt[1:0])) + $past(opb)));

  // R4: subtract wraps
  p_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ld_en && ins_op == OP_SUB) |=>
      regs[$past(ins_dst)] == DW'($past(opa) - $past(opb)));

  // R5: plain left shift
  p_shl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ld_en && ins_op == OP_SHL) |=>
      regs[$past(ins_dst)] == DW'($past(opa) << $past(ins_amt)));

  // R6: no-op and idle cycles leave state alone
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && (!ins_valid || ins_op == OP_NOP)) |=> $stable(regs));

  // R2: a load suppresses the instruction beside it
  p_ldprio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (regs[NREG-1:1] == $past(regs[NREG-1:1])));

endmodule

// File: tb/shadd_cmul_tb_top.sv
module shadd_cmul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic        ins_valid = 1'b0;
  logic [1:0]  ins_op = '0;
  logic [2:0]  ins_dst = '0, ins_srca = '0, ins_srcb = '0, rd_addr = '0;
  logic [4:0]  ins_amt = '0;
  logic [31:0] rd_data;

  int n_run = 0, n_fail = 0;
  logic [31:0] mdl [8];

  always #2 clk = ~clk;

  shadd_cmul dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
    .ins_valid(ins_valid), .ins_op(ins_op), .ins_dst(ins_dst),
    .ins_srca(ins_srca), .ins_srcb(ins_srcb), .ins_amt(ins_amt),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [31:0] ref_op(input logic [1:0] op, input logic [31:0] a,
                                         input logic [31:0] b, input logic [4:0] amt);
    case (op)
      2'b00:   return (a * (32'd1 << amt[1:0])) + b;
      2'b01:   return a - b;
      2'b10:   return a * (32'd1 << amt);
      default: return a;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic peek(input string req, input int r, input logic [31:0] exp);
    rd_addr = 3'(r);
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic load(input logic [31:0] s);
    @(negedge clk);
    ld_en = 1'b1; ld_data = s;
    @(posedge clk); #1;
    ld_en = 1'b0;
    mdl[0] = s;
  endtask

  task automatic issue(input logic [1:0] op, input int d, input int a, input int b,
                       input logic [4:0] amt);
    @(negedge clk);
    ins_valid = 1'b1; ins_op = op; ins_dst = 3'(d);
    ins_srca = 3'(a); ins_srcb = 3'(b); ins_amt = amt;
    @(posedge clk); #1;
    ins_valid = 1'b0;
    if (op != 2'b11) mdl[d] = ref_op(op, mdl[a], mdl[b], amt);
  endtask

  task automatic check_all(input string req);
    @(negedge clk);
    for (int i = 0; i < 8; i++) peek(req, i, mdl[i]);
  endtask

  task automatic run_chains(input logic [31:0] s);
    load(s);
    issue(2'b00, 1, 0, 0, 5'd2);
    issue(2'b00, 1, 1, 1, 5'd0);
    @(negedge clk); peek("R10 x10", 1, s * 32'd10);
    issue(2'b00, 2, 0, 0, 5'd1);
    issue(2'b00, 3, 2, 0, 5'd1);
    issue(2'b00, 3, 3, 2, 5'd3);
    @(negedge clk); peek("R10 x59", 3, s * 32'd59);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++; n_run++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    run_chains(32'd7);
    run_chains(32'hFFFF_FFFF);
    run_chains(32'h8000_0001);
    run_chains(32'd0);

    load(32'h1234_5678);
    issue(2'b00, 4, 0, 0, 5'b11101);
    @(negedge clk); peek("R3 high amt bits ignored", 4, 32'h1234_5678 * 32'd3);
    issue(2'b01, 5, 4, 0, 5'd0);
    @(negedge clk); peek("R4 subtract", 5, 32'h1234_5678 * 32'd2);
    issue(2'b01, 6, 0, 4, 5'd0);
    @(negedge clk); peek("R4 R8 negative wrap", 6, 32'h1234_5678 * 32'hFFFF_FFFE);
    issue(2'b10, 7, 0, 0, 5'd0);
    @(negedge clk); peek("R5 shift zero", 7, 32'h1234_5678);
    issue(2'b10, 7, 0, 0, 5'd31);
    @(negedge clk); peek("R5 shift 31", 7, 32'h0);
    issue(2'b10, 7, 0, 0, 5'd4);
    @(negedge clk); peek("R5 shift 4", 7, 32'h2345_6780);
    issue(2'b00, 1, 7, 7, 5'd3);
    @(negedge clk); peek("R7 dst is source", 1, 32'h2345_6780 * 32'd9);
    issue(2'b11, 2, 0, 0, 5'd3);
    check_all("R6 nop");
    repeat (3) @(negedge clk);
    check_all("R6 idle");

    @(negedge clk);
    ld_en = 1'b1; ld_data = 32'hCAFE_0001;
    ins_valid = 1'b1; ins_op = 2'b00; ins_dst = 3'd5; ins_srca = 3'd7; ins_srcb = 3'd7; ins_amt = 5'd0;
    @(posedge clk); #1;
    ld_en = 1'b0; ins_valid = 1'b0;
    mdl[0] = 32'hCAFE_0001;
    check_all("R2 load priority");

    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rd_addr = 3'(i); #1;
      check("R9 read port", rd_data, mdl[i]);
    end

    for (int k = 0; k < 40; k++) run_chains($urandom);

    for (int k = 0; k < 200; k++) begin
      if ($urandom_range(0, 9) == 0) load($urandom);
      issue(2'($urandom), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
            int'($urandom_range(0, 7)), 5'($urandom));
      if (k % 10 == 9) check_all("R3 R4 R5 R7 random");
    end
    check_all("R8 final state");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule